// File: doc/BRIEF.md
# Time-Slotted DMA Slot Arbiter

This block decides, one memory slot at a time, which requester owns the shared memory bus during a scan line. Ownership follows a fixed slot map rather than competition between requests. Odd slots are shared out by position among memory refresh, disk, the audio channels and the sprites. Even slots are offered to a display-list coprocessor. A bitplane fetch overrides the map in any slot while the vertical and horizontal fetch windows are both open. A slot that no one takes is flagged as free for the blitter/CPU path, which lies outside this block.

The beam logic drives the slot counter (0x00 to 0xE2, then wrapping) and the line number. Each requester presents a "would use this slot" signal. The arbiter registers its decision, so the outputs describe the slot that was presented on the previous clock. The outputs are a one-hot grant, the audio channel or sprite number served, the sprite word selector and the beam position handed to the coprocessor.

The horizontal fetch window is tracked by a three-state machine. `HW_IDLE` moves to `HW_OPEN` when the slot equals the window start value. `HW_OPEN` moves to `HW_DRAIN` when the slot equals the window end value, and at that point the stop slot is latched. `HW_DRAIN` returns to `HW_IDLE` when the slot equals the stop slot. The window is active in the start slot, throughout `HW_OPEN`, and in `HW_DRAIN` up to but not including the stop slot.

Top module: `dma_slot_arbiter`

## Requirements
- R1: A bitplane grant (grant bit 0) wins over every other owner in any slot. It is given only when the horizontal window is active, `vwin_i` is high, enable bit 6 is set and `bpl_req_i` is high.
- R2: When the slot equals `fetch_end_i`, the stop slot becomes `fetch_end_i` + 12 if `hires_i` is high and `fetch_end_i` + 8 if it is low. The window opens at `fetch_start_i` and is inactive in the stop slot itself.
- R3: Odd slots below 0x08 (0x01, 0x03, 0x05, 0x07) always go to refresh (grant bit 1) unless a bitplane fetch takes them. They are never free.
- R4: Odd slots 0x09 to 0x0D go to disk (grant bit 2) when enable bit 4 and `dsk_req_i` are both high. Otherwise they are free.
- R5: Odd slots 0x0F to 0x15 serve audio channel (slot − 0x0E) >> 1 (grant bit 3, `chan_o` = channel). The channel is gated by its own enable bit, bits 3:0 being channels 3:0, and by its request bit.
- R6: Odd slots 0x17 to 0x35 serve sprite (slot − 0x16) >> 2 (grant bit 4, `chan_o` = sprite number). This happens only when enable bit 5 is set, `line_i` ≥ `vblank_i` and that sprite requests. `spr_word_o` is the inverse of slot bit 1 for a sprite grant and 0 otherwise.
- R7: Even slots go to the coprocessor (grant bit 5) when enable bit 7 and `cop_req_i` are high. `beam_o` always carries {line[7:0], slot} of the slot decided.
- R8: Any slot not taken by R1 to R7 (including odd slots 0x37 and above) raises free (grant bit 6). Out of reset exactly one grant bit is high per clock, one clock after the slot is presented. Reset clears all outputs to zero. `chan_o` is 0 unless audio or a sprite is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 8 | Horizontal slot number |
| line_i | input | 9 | Current line number |
| dma_en_i | input | 8 | DMA enables: [3:0] audio, 4 disk, 5 sprite, 6 bitplane, 7 coprocessor |
| vblank_i | input | 9 | First line on which sprite fetches are allowed |
| vwin_i | input | 1 | Vertical fetch window active |
| fetch_start_i | input | 8 | Horizontal fetch window start slot |
| fetch_end_i | input | 8 | Horizontal fetch window end slot |
| hires_i | input | 1 | High-resolution mode (stop offset 12 instead of 8) |
| bpl_req_i | input | 1 | Bitplane wants this slot |
| dsk_req_i | input | 1 | Disk wants this slot |
| aud_req_i | input | 4 | Per-channel audio requests |
| spr_req_i | input | 8 | Per-sprite requests |
| cop_req_i | input | 1 | Coprocessor wants this slot |
| grant_o | output | 7 | One-hot owner: bpl, refresh, disk, audio, sprite, coprocessor, free |
| chan_o | output | 3 | Audio channel or sprite number served |
| spr_word_o | output | 1 | Sprite word selector |
| beam_o | output | 16 | Beam position {line[7:0], slot} |

## Verification
A wrong fetch-window state shows up as bitplane grants that start early, end late or leak into the stop slot. This is visible at `grant_o` on the clock after the faulty slot and persists until the next window event. A wrong stop offset shifts the last bitplane slot by four. The bench would see it at the first `hires_i` line that ends a window. Errors in the slot map or the channel derivation show up directly as a wrong grant bit or `chan_o` one clock after the slot. For that reason every slot of several full lines is compared under contrasting enables and request patterns.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int GNT_N = 7;
    localparam int GK_W  = 3;

    // grant bit positions
    localparam int GI_BPL  = 0;
    localparam int GI_REF  = 1;
    localparam int GI_DSK  = 2;
    localparam int GI_AUD  = 3;
    localparam int GI_SPR  = 4;
    localparam int GI_COP  = 5;
    localparam int GI_FREE = 6;

    typedef enum logic [1:0] {
        HW_IDLE  = 2'd0,
        HW_OPEN  = 2'd1,
        HW_DRAIN = 2'd2
    } hwin_e;
endpackage

// File: rtl/dma_hwin_fsm.sv
module dma_hwin_fsm
    import dma_arb_pkg::*;
#(
    parameter int SLOT_W   = 8,
    parameter int HI_EXTRA = 12,
    parameter int LO_EXTRA = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] win_start,
    input  logic [SLOT_W-1:0] win_end,
    input  logic              hires,
    output logic              active
);
    localparam logic [SLOT_W-1:0] HI_OFS = SLOT_W'(HI_EXTRA);
    localparam logic [SLOT_W-1:0] LO_OFS = SLOT_W'(LO_EXTRA);

    hwin_e             st_q, st_d;
    logic [SLOT_W-1:0] stop_q, stop_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= HW_IDLE;
            stop_q <= '0;
        end else begin
            st_q   <= st_d;
            stop_q <= stop_d;
        end
    end

    // transitions
    always_comb begin
        st_d   = st_q;
        stop_d = stop_q;
        unique case (st_q)
            HW_IDLE: begin
                if (slot == win_start) st_d = HW_OPEN;
            end
            HW_OPEN: begin
                if (slot == win_end) begin
                    st_d   = HW_DRAIN;
                    stop_d = win_end + (hires ? HI_OFS : LO_OFS);
                end
            end
            HW_DRAIN: begin
                if (slot == stop_q) st_d = HW_IDLE;
            end
            default: st_d = HW_IDLE;
        endcase
    end

    // window output for the slot being decided
    always_comb begin
        unique case (st_q)
            HW_IDLE:  active = (slot == win_start);
            HW_OPEN:  active = 1'b1;
            HW_DRAIN: active = (slot != stop_q);
            default:  active = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_slot_decode.sv
module dma_slot_decode
    import dma_arb_pkg::*;
#(
    parameter int SLOT_W    = 8,
    parameter int LINE_W    = 9,
    parameter int N_AUD     = 4,
    parameter int N_SPR     = 8,
    parameter int REF_SLOTS = 4,
    parameter int DSK_SLOTS = 3,
    parameter int IDX_W     = 3
) (
    input  logic [SLOT_W-1:0]  slot,
    input  logic [LINE_W-1:0]  line,
    input  logic [LINE_W-1:0]  vblank,
    input  logic [N_AUD+3:0]   dma_en,
    input  logic               hwin,
    input  logic               vwin,
    input  logic               bpl_req,
    input  logic               dsk_req,
    input  logic [N_AUD-1:0]   aud_req,
    input  logic [N_SPR-1:0]   spr_req,
    input  logic               cop_req,
    output logic [GK_W-1:0]    kind,
    output logic [IDX_W-1:0]   idx,
    output logic               spr_word
);
    localparam int EN_DSK = N_AUD;
    localparam int EN_SPR = N_AUD + 1;
    localparam int EN_BPL = N_AUD + 2;
    localparam int EN_COP = N_AUD + 3;
    localparam int AUD_W  = $clog2(N_AUD);
    localparam int SPR_W  = $clog2(N_SPR);

    // odd-slot region boundaries, each region two slots per owner step
    localparam logic [SLOT_W-1:0] DSK_LO = SLOT_W'(2 * REF_SLOTS);
    localparam logic [SLOT_W-1:0] AUD_LO = SLOT_W'(2 * REF_SLOTS + 2 * DSK_SLOTS);
    localparam logic [SLOT_W-1:0] SPR_LO = SLOT_W'(2 * REF_SLOTS + 2 * DSK_SLOTS + 2 * N_AUD);
    localparam logic [SLOT_W-1:0] SPR_HI = SLOT_W'(2 * REF_SLOTS + 2 * DSK_SLOTS + 2 * N_AUD + 4 * N_SPR);

    logic [AUD_W-1:0] a_ch;
    logic [SPR_W-1:0] s_id;

    assign a_ch = AUD_W'((slot - AUD_LO) >> 1);
    assign s_id = SPR_W'((slot - SPR_LO) >> 2);

    always_comb begin
        kind     = GK_W'(GI_FREE);
        idx      = '0;
        spr_word = 1'b0;
        if (dma_en[EN_BPL] && vwin && hwin && bpl_req) begin
            kind = GK_W'(GI_BPL);
        end else if (slot[0]) begin
            if (slot < DSK_LO) begin
                kind = GK_W'(GI_REF);
            end else if (slot < AUD_LO) begin
                if (dma_en[EN_DSK] && dsk_req) kind = GK_W'(GI_DSK);
            end else if (slot < SPR_LO) begin
                if (dma_en[a_ch] && aud_req[a_ch]) begin
                    kind = GK_W'(GI_AUD);
                    idx  = IDX_W'(a_ch);
                end
            end else if (slot < SPR_HI) begin
                if (dma_en[EN_SPR] && (line >= vblank) && spr_req[s_id]) begin
                    kind     = GK_W'(GI_SPR);
                    idx      = IDX_W'(s_id);
                    spr_word = ~slot[1];
                end
            end
        end else if (dma_en[EN_COP] && cop_req) begin
            kind = GK_W'(GI_COP);
        end
    end
endmodule

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter
    import dma_arb_pkg::*;
#(
    parameter int SLOT_W = 8,
    parameter int LINE_W = 9,
    parameter int N_AUD  = 4,
    parameter int N_SPR  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOT_W-1:0]        slot_i,
    input  logic [LINE_W-1:0]        line_i,
    input  logic [N_AUD+3:0]         dma_en_i,
    input  logic [LINE_W-1:0]        vblank_i,
    input  logic                     vwin_i,
    input  logic [SLOT_W-1:0]        fetch_start_i,
    input  logic [SLOT_W-1:0]        fetch_end_i,
    input  logic                     hires_i,
    input  logic                     bpl_req_i,
    input  logic                     dsk_req_i,
    input  logic [N_AUD-1:0]         aud_req_i,
    input  logic [N_SPR-1:0]         spr_req_i,
    input  logic                     cop_req_i,
    output logic [GNT_N-1:0]         grant_o,
    output logic [2:0]               chan_o,
    output logic                     spr_word_o,
    output logic [SLOT_W+7:0]        beam_o
);
    localparam int IDX_W = 3;

    logic              hwin;
    logic [GK_W-1:0]   kind;
    logic [IDX_W-1:0]  idx;
    logic              sw;
    logic [GNT_N-1:0]  gnt_d;

    dma_hwin_fsm #(
        .SLOT_W (SLOT_W)
    ) u_hwin (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot_i),
        .win_start (fetch_start_i),
        .win_end   (fetch_end_i),
        .hires     (hires_i),
        .active    (hwin)
    );

    dma_slot_decode #(
        .SLOT_W (SLOT_W),
        .LINE_W (LINE_W),
        .N_AUD  (N_AUD),
        .N_SPR  (N_SPR),
        .IDX_W  (IDX_W)
    ) u_dec (
        .slot     (slot_i),
        .line     (line_i),
        .vblank   (vblank_i),
        .dma_en   (dma_en_i),
        .hwin     (hwin),
        .vwin     (vwin_i),
        .bpl_req  (bpl_req_i),
        .dsk_req  (dsk_req_i),
        .aud_req  (aud_req_i),
        .spr_req  (spr_req_i),
        .cop_req  (cop_req_i),
        .kind     (kind),
        .idx      (idx),
        .spr_word (sw)
    );

    for (genvar g = 0; g < GNT_N; g++) begin : g_onehot
        assign gnt_d[g] = (kind == GK_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o    <= '0;
            chan_o     <= '0;
            spr_word_o <= 1'b0;
            beam_o     <= '0;
        end else begin
            grant_o    <= gnt_d;
            chan_o     <= idx;
            spr_word_o <= sw;
            beam_o     <= {line_i[7:0], slot_i};
        end
    end
endmodule

// File: rtl/dma_slot_arbiter_chk.sv
module dma_slot_arbiter_chk
    import dma_arb_pkg::*;
#(
    parameter int SLOT_W = 8,
    parameter int LINE_W = 9,
    parameter int EN_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SLOT_W-1:0] slot_i,
    input logic [LINE_W-1:0] line_i,
    input logic [EN_W-1:0]   dma_en_i,
    input logic [LINE_W-1:0] vblank_i,
    input logic              vwin_i,
    input logic [GNT_N-1:0]  grant_o
);
    localparam int EN_DSK = EN_W - 4;
    localparam int EN_SPR = EN_W - 3;
    localparam int EN_BPL = EN_W - 2;
    localparam int EN_COP = EN_W - 1;

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> $onehot(grant_o)); // R8

    AST_BPL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && grant_o[GI_BPL]) |-> ($past(vwin_i) && $past(dma_en_i[EN_BPL]))); // R1

    AST_REFRESH_LOW_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && grant_o[GI_REF]) |-> ($past(slot_i[0]) && ($past(slot_i) < SLOT_W'(8)))); // R3

    AST_DISK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && grant_o[GI_DSK]) |-> ($past(slot_i[0]) && $past(dma_en_i[EN_DSK]))); // R4

    AST_SPRITE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && grant_o[GI_SPR]) |-> (($past(line_i) >= $past(vblank_i)) && $past(dma_en_i[EN_SPR]))); // R6

    AST_COP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && grant_o[GI_COP]) |-> (!$past(slot_i[0]) && $past(dma_en_i[EN_COP]))); // R7
endmodule

bind dma_slot_arbiter dma_slot_arbiter_chk u_chk (.*);

// File: tb/dma_slot_arbiter_test.sv
`timescale 1ns/1ps
module dma_slot_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  slot_i = '0;
    logic [8:0]  line_i = '0;
    logic [7:0]  dma_en_i = '0;
    logic [8:0]  vblank_i = '0;
    logic        vwin_i = 1'b0;
    logic [7:0]  fetch_start_i = 8'hFF;
    logic [7:0]  fetch_end_i = 8'hFF;
    logic        hires_i = 1'b0;
    logic        bpl_req_i = 1'b0;
    logic        dsk_req_i = 1'b0;
    logic [3:0]  aud_req_i = '0;
    logic [7:0]  spr_req_i = '0;
    logic        cop_req_i = 1'b0;
    logic [6:0]  grant_o;
    logic [2:0]  chan_o;
    logic        spr_word_o;
    logic [15:0] beam_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the horizontal window: 0 idle, 1 open, 2 draining
    int hs = 0;
    int hstop = 0;

    always #4 clk = ~clk;

    dma_slot_arbiter uut (.*);

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(int k);
        case (k)
            0: return "R1 R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [14:0] req_pat(int s, int l, int mode);
        int h;
        if (mode == 0) return '1;
        h = s * 37 + l * 11 + mode * 5;
        h = h ^ (h >> 3) ^ (h << 2);
        return 15'(h);
    endfunction

    // one slot: drive, predict, let one edge pass, compare
    task automatic do_slot(int s, int l, int en, int vb, bit vw, int st, int en_end,
                           bit hr, int mode);
        logic [14:0] r;
        bit hw;
        int k, ix, sw, ch, id;
        r = req_pat(s, l, mode);
        slot_i = 8'(s); line_i = 9'(l); dma_en_i = 8'(en); vblank_i = 9'(vb);
        vwin_i = vw; fetch_start_i = 8'(st); fetch_end_i = 8'(en_end); hires_i = hr;
        bpl_req_i = r[0]; dsk_req_i = r[1]; aud_req_i = r[5:2];
        spr_req_i = r[13:6]; cop_req_i = r[14];

        hw = (hs != 0 || s == st) && !(hs == 2 && s == hstop);
        case (hs)
            0: if (s == st) hs = 1;
            1: if (s == en_end) begin hs = 2; hstop = (en_end + (hr ? 12 : 8)) & 255; end
            default: if (s == hstop) hs = 0;
        endcase

        k = 6; ix = 0; sw = 0;
        if (en[6] && vw && hw && r[0]) k = 0;
        else if (s % 2 == 1) begin
            if (s < 8) k = 1;
            else if (s < 14) begin if (en[4] && r[1]) k = 2; end
            else if (s < 22) begin
                ch = (s - 14) / 2;
                if (en[ch] && r[2 + ch]) begin k = 3; ix = ch; end
            end else if (s < 54) begin
                id = (s - 22) / 4;
                if (en[5] && l >= vb && r[6 + id]) begin k = 4; ix = id; sw = ((s / 2) % 2 == 1) ? 0 : 1; end
            end
        end else if (en[7] && r[14]) k = 5;

        @(negedge clk);
        check(tag_of(k), $sformatf("grant slot %0h line %0d", s, l), int'(grant_o), 1 << k);
        check(k == 3 ? "R5" : (k == 4 ? "R6" : "R8"), $sformatf("chan slot %0h", s), int'(chan_o), ix);
        check("R6", $sformatf("sprite word slot %0h", s), int'(spr_word_o), sw);
        check("R7", $sformatf("beam slot %0h", s), int'(beam_o), ((l & 255) << 8) | s);
    endtask

    task automatic do_line(int l, int en, int vb, bit vw, int st, int en_end, bit hr, int mode);
        for (int s = 0; s <= 8'hE2; s++) do_slot(s, l, en, vb, vw, st, en_end, hr, mode);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "reset grant", int'(grant_o), 0);
        check("R8", "reset chan", int'(chan_o), 0);
        check("R8", "reset beam", int'(beam_o), 0);
        rst_n = 1'b1;
        // full map, all requesting, no bitplanes: R3 R4 R5 R6 R7 R8
        do_line(30, 8'hFF, 25, 1'b0, 8'hFF, 8'hFF, 1'b0, 0);
        // lores window 0x38..0xD0, stop 0xD8, sparse requests: R1 R2
        do_line(40, 8'hFF, 25, 1'b1, 8'h38, 8'hD0, 1'b0, 1);
        // sprites blocked above vblank, bitplane and disk disabled, hires: R6 R4 R1
        do_line(10, 8'hA5, 25, 1'b1, 8'h20, 8'h40, 1'b1, 0);
        // line above 255, hires window 0x18..0x30, stop 0x3C: R2 R7
        do_line(300, 8'h5A, 25, 1'b1, 8'h18, 8'h30, 1'b1, 0);
        // bitplane window over refresh slots, lores stop 0x0C: R1 R3
        do_line(50, 8'hFF, 25, 1'b1, 8'h02, 8'h04, 1'b0, 0);
        // nothing enabled: only refresh and free: R3 R8
        do_line(60, 8'h00, 25, 1'b1, 8'h10, 8'h20, 1'b0, 0);
        // sparse requests, line equal to vblank: R6
        do_line(25, 8'hFF, 25, 1'b0, 8'hFF, 8'hFF, 1'b0, 2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule